// File: doc/BRIEF.md
# Coarse Tuning Ratio Self-Calibration Engine

This block trims the ratio that turns a frequency offset into a coarse oscillator tuning word. It does this in the foreground, before the loop runs normally. The offset input is the normalised frequency offset: command word minus the free-running frequency over the reference frequency. From that offset and a 3.3 fixed-point ratio the block computes a coarse word estimate, which is the integer part of their product. A sequential shift-and-add multiplier does the multiplication.

A calibration starts on a strobe, and the ratio is loaded with its ideal code (5.25). The block then takes one coarse word that the loop reached by itself. Each new estimate is compared with that word, and the ratio moves one step of 1/8 towards equality. When the two words are equal, the ratio freezes and the block goes idle with a done flag. A miss flag is raised instead when equality cannot be reached, either because the ratio is at its bound or because the search would reverse direction.

Top module: `ratio_trim_cal`

## Requirements
- R1: After reset, `idle_o`=1, `done_o`=0, `miss_o`=0, `ratio_o`=42 (5.25 in 3.3 format) and `estimate_o`=0.
- R2: A `start_i` pulse while idle latches `offset_i`, loads `ratio_o` with 42 and clears `done_o` and `miss_o`. In the following cycle `idle_o` is 0.
- R3: The reference coarse word is `settled_i`, taken on `settled_vld_i` in the start cycle or, failing that, on the first valid after it. Any later valid strobe during the same calibration has no effect.
- R4: `offset_i` is unsigned with 15 fractional bits and the ratio has 3. The estimate is the product's bits [28:18]. If that value exceeds 255 the estimate is 255.
- R5: If the estimate is above the reference, the ratio is decreased by one code (0.125). If it is below, the ratio is increased by one code. A new estimate is then computed and compared.
- R6: When the estimate equals the reference, the block returns to idle with `done_o`=1. `ratio_o` holds the final ratio and `estimate_o` equals the reference.
- R7: If a step would take the ratio below 0 or above 63, the block stops with `miss_o`=1. The ratio stays at the bound and `estimate_o` shows the last estimate.
- R8: If a step would go in the opposite direction to the previous step, the block stops with `miss_o`=1. The ratio stays at the last evaluated code.
- R9: A `start_i` pulse while a calibration is running has no effect on its result.
- R10: While idle and without a start pulse, `ratio_o` and `estimate_o` stay unchanged. This holds even when `settled_vld_i` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Calibration start strobe |
| offset_i | input | 23 | Normalised frequency offset, 8.15 unsigned |
| settled_i | input | 8 | Coarse word reached by the loop |
| settled_vld_i | input | 1 | Valid strobe for `settled_i` |
| ratio_o | output | 6 | Ratio code, 3.3 unsigned |
| estimate_o | output | 8 | Last computed coarse word estimate |
| done_o | output | 1 | Calibration reached equality |
| miss_o | output | 1 | Calibration stopped without equality |
| idle_o | output | 1 | No calibration in progress |

## Verification
The start strobe and the reference valid strobe can arrive in the same cycle. The block must then capture the reference at once rather than wait for a later strobe. The bench drives both in one cycle and afterwards pulses valid again with a different word. The final ratio must match the first word, which shows the later strobe was ignored. A second collision is a start pulse during a multiplication. That pulse carries a different offset, and the result must still follow the offset latched at the real start.

// File: rtl/ratcal_pkg.sv
package ratcal_pkg;
  localparam int OFFSET_W_DEF = 23;
  localparam int OFFSET_FRAC_DEF = 15;
  localparam int RATIO_W_DEF = 6;
  localparam int RATIO_FRAC_DEF = 3;
  localparam int WORD_W_DEF = 8;
  localparam int RATIO_INIT_DEF = 42;

  typedef enum logic [1:0] {
    CS_IDLE,
    CS_WAIT,
    CS_LAUNCH,
    CS_MUL
  } cal_state_t;

  typedef enum logic [1:0] {
    STEP_NONE,
    STEP_UP,
    STEP_DOWN
  } step_dir_t;
endpackage

// File: rtl/ratcal_shiftmul.sv
module ratcal_shiftmul #(
  parameter int A_W = 23,
  parameter int B_W = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               go_i,
  input  logic [A_W-1:0]     a_i,
  input  logic [B_W-1:0]     b_i,
  output logic [A_W+B_W-1:0] prod_o,
  output logic               vld_o
);
  localparam int P_W = A_W + B_W;
  localparam int CNT_W = $clog2(B_W + 1);

  logic [P_W-1:0]   acc_q;
  logic [P_W-1:0]   mcand_q;
  logic [B_W-1:0]   mplr_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      mcand_q <= '0;
      mplr_q  <= '0;
      cnt_q   <= '0;
      vld_o   <= 1'b0;
    end else begin
      vld_o <= 1'b0;
      if (go_i) begin
        acc_q   <= '0;
        mcand_q <= {{B_W{1'b0}}, a_i};
        mplr_q  <= b_i;
        cnt_q   <= CNT_W'(B_W);
      end else if (cnt_q != '0) begin
        if (mplr_q[0]) acc_q <= acc_q + mcand_q;
        mcand_q <= mcand_q << 1;
        mplr_q  <= mplr_q >> 1;
        cnt_q   <= cnt_q - CNT_W'(1);
        if (cnt_q == CNT_W'(1)) vld_o <= 1'b1;
      end
    end
  end

  assign prod_o = acc_q;
endmodule

// File: rtl/ratcal_intclamp.sv
module ratcal_intclamp #(
  parameter int P_W    = 29,
  parameter int FRAC_W = 18,
  parameter int WORD_W = 8
) (
  input  logic [P_W-1:0]    prod_i,
  output logic [WORD_W-1:0] word_o
);
  localparam int INT_W = P_W - FRAC_W;

  logic [INT_W-1:0] int_part;
  assign int_part = prod_i[P_W-1:FRAC_W];

  generate
    if (INT_W > WORD_W) begin : g_clamp
      always_comb begin
        if (int_part > INT_W'({WORD_W{1'b1}})) word_o = {WORD_W{1'b1}};
        else word_o = int_part[WORD_W-1:0];
      end
    end else begin : g_extend
      assign word_o = WORD_W'(int_part);
    end
  endgenerate
endmodule

// File: rtl/ratcal_ctrl.sv
module ratcal_ctrl
  import ratcal_pkg::*;
#(
  parameter int OFFSET_W   = 23,
  parameter int RATIO_W    = 6,
  parameter int WORD_W     = 8,
  parameter int RATIO_INIT = 42
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_i,
  input  logic [OFFSET_W-1:0] offset_i,
  input  logic [WORD_W-1:0]   settled_i,
  input  logic                settled_vld_i,
  input  logic [WORD_W-1:0]   est_i,
  input  logic                prod_vld_i,
  output logic                go_o,
  output logic [OFFSET_W-1:0] offset_o,
  output logic [RATIO_W-1:0]  ratio_o,
  output logic [WORD_W-1:0]   estimate_o,
  output logic                done_o,
  output logic                miss_o,
  output logic                idle_o
);
  localparam logic [RATIO_W-1:0] RAT_MAX = {RATIO_W{1'b1}};
  localparam logic [RATIO_W-1:0] RAT_INI = RATIO_W'(RATIO_INIT);

  cal_state_t        st_q;
  step_dir_t         dir_q;
  logic [WORD_W-1:0] ref_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= CS_IDLE;
      dir_q      <= STEP_NONE;
      ref_q      <= '0;
      offset_o   <= '0;
      ratio_o    <= RAT_INI;
      estimate_o <= '0;
      done_o     <= 1'b0;
      miss_o     <= 1'b0;
    end else begin
      case (st_q)
        CS_IDLE: begin
          if (start_i) begin
            offset_o <= offset_i;
            ratio_o  <= RAT_INI;
            done_o   <= 1'b0;
            miss_o   <= 1'b0;
            dir_q    <= STEP_NONE;
            if (settled_vld_i) begin
              ref_q <= settled_i;
              st_q  <= CS_LAUNCH;
            end else begin
              st_q <= CS_WAIT;
            end
          end
        end
        CS_WAIT: begin
          if (settled_vld_i) begin
            ref_q <= settled_i;
            st_q  <= CS_LAUNCH;
          end
        end
        CS_LAUNCH: st_q <= CS_MUL;
        CS_MUL: begin
          if (prod_vld_i) begin
            estimate_o <= est_i;
            if (est_i == ref_q) begin
              done_o <= 1'b1;
              st_q   <= CS_IDLE;
            end else if (est_i > ref_q) begin
              if (dir_q == STEP_UP || ratio_o == '0) begin
                miss_o <= 1'b1;
                st_q   <= CS_IDLE;
              end else begin
                ratio_o <= ratio_o - RATIO_W'(1);
                dir_q   <= STEP_DOWN;
                st_q    <= CS_LAUNCH;
              end
            end else begin
              if (dir_q == STEP_DOWN || ratio_o == RAT_MAX) begin
                miss_o <= 1'b1;
                st_q   <= CS_IDLE;
              end else begin
                ratio_o <= ratio_o + RATIO_W'(1);
                dir_q   <= STEP_UP;
                st_q    <= CS_LAUNCH;
              end
            end
          end
        end
        default: st_q <= CS_IDLE;
      endcase
    end
  end

  assign go_o   = (st_q == CS_LAUNCH);
  assign idle_o = (st_q == CS_IDLE);
endmodule

// File: rtl/ratio_trim_cal.sv
module ratio_trim_cal
  import ratcal_pkg::*;
#(
  parameter int OFFSET_W    = OFFSET_W_DEF,
  parameter int OFFSET_FRAC = OFFSET_FRAC_DEF,
  parameter int RATIO_W     = RATIO_W_DEF,
  parameter int RATIO_FRAC  = RATIO_FRAC_DEF,
  parameter int WORD_W      = WORD_W_DEF,
  parameter int RATIO_INIT  = RATIO_INIT_DEF
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_i,
  input  logic [OFFSET_W-1:0] offset_i,
  input  logic [WORD_W-1:0]   settled_i,
  input  logic                settled_vld_i,
  output logic [RATIO_W-1:0]  ratio_o,
  output logic [WORD_W-1:0]   estimate_o,
  output logic                done_o,
  output logic                miss_o,
  output logic                idle_o
);
  localparam int PROD_W = OFFSET_W + RATIO_W;
  localparam int PROD_FRAC = OFFSET_FRAC + RATIO_FRAC;

  logic                go;
  logic [OFFSET_W-1:0] offset_q;
  logic [PROD_W-1:0]   prod;
  logic                prod_vld;
  logic [WORD_W-1:0]   est_word;

  ratcal_ctrl #(
    .OFFSET_W(OFFSET_W), .RATIO_W(RATIO_W), .WORD_W(WORD_W), .RATIO_INIT(RATIO_INIT)
  ) u_ctrl (
    .clk(clk), .rst(rst), .start_i(start_i), .offset_i(offset_i),
    .settled_i(settled_i), .settled_vld_i(settled_vld_i),
    .est_i(est_word), .prod_vld_i(prod_vld), .go_o(go), .offset_o(offset_q),
    .ratio_o(ratio_o), .estimate_o(estimate_o), .done_o(done_o),
    .miss_o(miss_o), .idle_o(idle_o)
  );

  ratcal_shiftmul #(.A_W(OFFSET_W), .B_W(RATIO_W)) u_mul (
    .clk(clk), .rst(rst), .go_i(go), .a_i(offset_q), .b_i(ratio_o),
    .prod_o(prod), .vld_o(prod_vld)
  );

  ratcal_intclamp #(.P_W(PROD_W), .FRAC_W(PROD_FRAC), .WORD_W(WORD_W)) u_clamp (
    .prod_i(prod), .word_o(est_word)
  );
endmodule

// File: rtl/ratio_trim_cal_chk.sv
module ratio_trim_cal_chk #(
  parameter int RATIO_W    = 6,
  parameter int WORD_W     = 8,
  parameter int RATIO_INIT = 42
) (
  input logic               clk,
  input logic               rst,
  input logic               start_i,
  input logic [RATIO_W-1:0] ratio_o,
  input logic [WORD_W-1:0]  estimate_o,
  input logic               done_o,
  input logic               miss_o,
  input logic               idle_o
);
  logic [RATIO_W:0] r_now;
  assign r_now = {1'b0, ratio_o};

  a_r2_start_loads: assert property (@(posedge clk) disable iff (rst)
    (start_i && idle_o) |=> (!idle_o && !done_o && !miss_o && ratio_o == RATIO_W'(RATIO_INIT)));

  a_r5_unit_step: assert property (@(posedge clk) disable iff (rst)
    (!idle_o && $past(!idle_o)) |->
      (r_now == $past(r_now) || r_now == $past(r_now) + 1'b1 || r_now + 1'b1 == $past(r_now)));

  a_r6_done_idle: assert property (@(posedge clk) disable iff (rst)
    done_o |-> idle_o);

  a_r7_flags_excl: assert property (@(posedge clk) disable iff (rst)
    $onehot0({done_o, miss_o}));

  a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (idle_o && !start_i) |=> ($stable(ratio_o) && $stable(estimate_o)));
endmodule

bind ratio_trim_cal ratio_trim_cal_chk #(
  .RATIO_W(RATIO_W), .WORD_W(WORD_W), .RATIO_INIT(RATIO_INIT)
) u_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .ratio_o(ratio_o),
  .estimate_o(estimate_o), .done_o(done_o), .miss_o(miss_o), .idle_o(idle_o)
);

// File: tb/ratio_trim_cal_tb.sv
module ratio_trim_cal_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [22:0] offset_i = '0;
  logic [7:0]  settled_i = '0;
  logic        settled_vld_i = 1'b0;
  logic [5:0]  ratio_o;
  logic [7:0]  estimate_o;
  logic        done_o, miss_o, idle_o;

  int n_checks = 0;
  int n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ratio_trim_cal u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .offset_i(offset_i),
    .settled_i(settled_i), .settled_vld_i(settled_vld_i), .ratio_o(ratio_o),
    .estimate_o(estimate_o), .done_o(done_o), .miss_o(miss_o), .idle_o(idle_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Expected result from the requirements (R4, R5, R6, R7, R8).
  function automatic void model(input int ofs, input int rf,
                                output int r, output int e, output bit miss);
    int dir = 0;
    r = 42;
    miss = 0;
    for (int k = 0; k < 200; k++) begin
      e = (ofs * r) >>> 18;
      if (e > 255) e = 255;
      if (e == rf) return;
      if (e > rf) begin
        if (dir == 1 || r == 0) begin miss = 1; return; end
        r--; dir = -1;
      end else begin
        if (dir == -1 || r == 63) begin miss = 1; return; end
        r++; dir = 1;
      end
    end
  endfunction

  task automatic wait_idle();
    for (int k = 0; k < 5000; k++) begin
      @(negedge clk);
      if (idle_o) return;
    end
  endtask

  // mode 0: valid later; 1: valid with start; 2: valid later plus busy interference
  task automatic run_cal(input int ofs, input int rf, input int mode, input string tag);
    int er, ee;
    bit em;
    model(ofs, rf, er, ee, em);
    @(negedge clk);
    start_i = 1'b1;
    offset_i = 23'(ofs);
    if (mode == 1) begin settled_i = 8'(rf); settled_vld_i = 1'b1; end
    @(negedge clk);
    start_i = 1'b0;
    settled_vld_i = 1'b0;
    offset_i = '0;
    chk(!idle_o && !done_o && !miss_o && ratio_o == 6'd42, "R2", "start load",
        {idle_o, done_o, miss_o, ratio_o}, 42);
    if (mode != 1) begin
      repeat (3) @(negedge clk);
      settled_i = 8'(rf);
      settled_vld_i = 1'b1;
      @(negedge clk);
      settled_vld_i = 1'b0;
    end
    if (mode == 2) begin
      // R9: start while busy, R3: later valid strobe during the run
      @(negedge clk);
      start_i = 1'b1;
      offset_i = 23'(255 << 15);
      @(negedge clk);
      start_i = 1'b0;
      settled_i = 8'(rf + 3);
      settled_vld_i = 1'b1;
      @(negedge clk);
      settled_vld_i = 1'b0;
      offset_i = '0;
    end
    if (mode == 1) begin
      // R3: a later valid with another word must be ignored
      @(negedge clk);
      settled_i = 8'(rf + 1);
      settled_vld_i = 1'b1;
      @(negedge clk);
      settled_vld_i = 1'b0;
    end
    wait_idle();
    chk(idle_o, tag, "idle at end", idle_o, 1);
    chk(int'(ratio_o) == er, tag, "ratio", ratio_o, er);
    chk(int'(estimate_o) == ee, tag, "estimate", estimate_o, ee);
    chk(done_o == !em && miss_o == em, tag, "done/miss", {done_o, miss_o},
        {!em, em});
  endtask

  task automatic test_reset();
    chk(idle_o && !done_o && !miss_o, "R1", "flags", {idle_o, done_o, miss_o}, 4);
    chk(ratio_o == 6'd42, "R1", "ratio", ratio_o, 42);
    chk(estimate_o == 8'd0, "R1", "estimate", estimate_o, 0);
  endtask

  task automatic test_idle_hold();
    logic [5:0] r0;
    logic [7:0] e0;
    r0 = ratio_o;
    e0 = estimate_o;
    @(negedge clk);
    settled_i = 8'd7;
    settled_vld_i = 1'b1;
    @(negedge clk);
    settled_vld_i = 1'b0;
    repeat (20) @(negedge clk);
    chk(ratio_o == r0 && estimate_o == e0 && idle_o, "R10", "idle hold",
        {ratio_o, estimate_o}, {r0, e0});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    test_reset();
    run_cal(8 << 15, 42, 0, "R6 equal at init");
    run_cal(7 * 32768 + 16384, 39, 0, "R4 truncation");
    run_cal(8 << 15, 38, 0, "R5 decrease");
    run_cal(7 * 32768 + 16384, 37, 0, "R5 decrease fractional");
    run_cal(8 << 15, 50, 0, "R5 increase");
    run_cal(255 << 15, 255, 0, "R4 clamp");
    run_cal(1 << 15, 200, 0, "R7 upper bound");
    run_cal(16 << 15, 41, 0, "R8 reversal");
    run_cal(8 << 15, 44, 1, "R3 same cycle");
    run_cal(8 << 15, 40, 2, "R9 busy start");
    test_idle_hold();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule